// File: doc/BRIEF.md
# Segmented Real-Mode Memory Access Unit

This unit sits between an execution core and a single-port, byte-wide RAM of one mebibyte. The core names one of four segment registers, gives a 16-bit offset, and asks for a byte or a little-endian 16-bit word. The access can be a read, a write or a read-modify-write. The unit shifts the segment value left by four bits and adds the offset, keeping 20 bits. A word is always moved as two byte cycles, low byte first.

A word can wrap in two ways, and each is handled in its own way. If the offset is 0xFFFF, the high byte comes from offset 0x0000 of the same segment. If the physical address is 0xFFFFF, the high byte comes from physical 0x00000. Segment bases are cached in registers. They are rebuilt only when the core reports a segment-register write, and they are loaded with reset values when reset is asserted. For a read-modify-write, the unit keeps both byte addresses after returning the old value. It then waits for a write-back strobe carrying the new value and writes it to those same addresses.

Requests and responses use valid/ready handshakes. A request is taken on a cycle where `req_valid` and `req_ready` are both high. `req_ready` is high only while the unit is idle, so one access at most is ever in flight. A response stays presented, unchanged, until the core raises `rsp_ready`. The segment-update pins and the write-back strobe are plain pins with no handshake.

Top module: `seg_mem_unit`

## Requirements
- R1: The physical address of a byte is ((segment << 4) + offset) mod 2^20. A word's low byte is at that address and its high byte is at the next byte position. The high byte is returned in `rsp_rdata[15:8]`.
- R2: `req_sel` codes are 0 = ES, 1 = CS, 2 = SS and 3 = DS. The codes 4 to 7 use the DS base.
- R3: After reset the CS value is 0xFFFF and ES, SS and DS are 0. A word read at CS offset 0 therefore returns the bytes at 0xFFFF0 and 0xFFFF1.
- R4: A pulse on `seg_wr_en` loads `seg_wr_val` into the register chosen by `seg_wr_sel` (0 = ES, 1 = CS, 2 = SS, 3 = DS). Every request accepted after that clock edge uses the new value.
- R5: A word at offset 0xFFFF takes its high byte from offset 0x0000 of the same segment. It does not take it from the next linear address.
- R6: A word whose low byte is at physical 0xFFFFF takes its high byte from physical 0x00000.
- R7: A word access makes exactly two RAM cycles (`mem_en` high), low address first. A byte access makes exactly one.
- R8: `req_op` = 1 writes `req_wdata` (a word, or its low byte for a byte access) and then gives a response. `mem_we` is high only together with `mem_en`.
- R9: For `req_op` = 2, the response carries the old data. The unit then holds `req_ready` low and makes no RAM cycle until `wb_valid`. On `wb_valid` it writes `wb_data` to the same byte addresses. A `wb_valid` pulse at any other time is ignored.
- R10: After an accepted request, `req_ready` is low on the next cycle. While `rsp_valid` is high and `rsp_ready` is low, the response stays valid and `rsp_rdata` stays stable.
- R11: After reset, `req_ready` is 1, `rsp_valid` is 0 and no RAM cycle is made while the unit is idle. `req_op` = 3 behaves as a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| seg_wr_en | input | 1 | Segment register written this cycle |
| seg_wr_sel | input | 2 | Which segment register was written |
| seg_wr_val | input | 16 | New segment value |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Unit can accept a request |
| req_sel | input | 3 | Segment select |
| req_off | input | 16 | Offset within segment |
| req_word | input | 1 | 1 = word, 0 = byte |
| req_op | input | 2 | 0 read, 1 write, 2 read-modify-write, 3 read |
| req_wdata | input | 16 | Write data |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Core takes the response |
| rsp_rdata | output | 16 | Read data, byte reads zero-extended |
| wb_valid | input | 1 | Write-back strobe for a pending read-modify-write |
| wb_data | input | 16 | Write-back value |
| mem_en | output | 1 | RAM cycle this clock |
| mem_we | output | 1 | RAM write enable |
| mem_addr | output | 20 | RAM byte address |
| mem_wdata | output | 8 | RAM write byte |
| mem_rdata | input | 8 | RAM read byte, valid one cycle after the read |

## Verification
The segment registers are set to four values, 0x0000, 0x1234, 0xF000 and 0xFFFF, and the values are rotated across the registers. Every select code is then tried with offsets at 0, 1, 0x000F, 0x7FFE, 0xFFFE and 0xFFFF. This separates the plain linear case from the segment-end wrap at offset 0xFFFF, and both of these from the physical-end wrap that segment 0xFFFF with offset 0x000F produces. The rotation shows that each select code reaches the right base, and that codes 4 to 7 follow DS. Word writes read back as words and as bytes, and the full RAM image is compared at the end, so a high byte sent to the wrong address is caught. Separate cases cover the reset CS value, held responses, the read-modify-write hold with its write-back, and a stray write-back strobe.

// File: rtl/segmem_pkg.sv
package segmem_pkg;

  typedef enum logic [1:0] {
    SEG_ES = 2'd0,
    SEG_CS = 2'd1,
    SEG_SS = 2'd2,
    SEG_DS = 2'd3
  } seg_id_e;

  typedef enum logic [1:0] {
    OP_RD  = 2'd0,
    OP_WR  = 2'd1,
    OP_RMW = 2'd2,
    OP_RD2 = 2'd3
  } op_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LO,
    ST_HI,
    ST_TAIL,
    ST_RSP,
    ST_WAIT_WB,
    ST_WB_LO,
    ST_WB_HI
  } acc_state_e;

endpackage

// File: rtl/seg_base_cache.sv
module seg_base_cache #(
  parameter int SEG_W = 16,
  parameter int SHIFT = 4,
  parameter int NSEG  = 4,
  parameter int PA_W  = SEG_W + SHIFT,
  parameter int RESET_IDX = 1,
  localparam int SEL_W = $clog2(NSEG)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_en,
  input  logic [SEL_W-1:0]           wr_sel,
  input  logic [SEG_W-1:0]           wr_val,
  output logic [NSEG-1:0][PA_W-1:0]  bases
);

  for (genvar i = 0; i < NSEG; i++) begin : g_base
    localparam logic [PA_W-1:0] RST_BASE =
      (i == RESET_IDX) ? (PA_W'({SEG_W{1'b1}}) << SHIFT) : '0;

    always_ff @(posedge clk) begin
      if (!rst_n)
        bases[i] <= RST_BASE;
      else if (wr_en && (wr_sel == SEL_W'(i)))
        bases[i] <= PA_W'(wr_val) << SHIFT;
    end
  end

endmodule

// File: rtl/seg_addr_gen.sv
module seg_addr_gen
  import segmem_pkg::*;
#(
  parameter int OFF_W = 16,
  parameter int PA_W  = 20,
  parameter int NSEG  = 4,
  parameter int REQ_SEL_W = 3
) (
  input  logic [NSEG-1:0][PA_W-1:0] bases,
  input  logic [REQ_SEL_W-1:0]      sel,
  input  logic [OFF_W-1:0]          off,
  output logic [PA_W-1:0]           lo_addr,
  output logic [PA_W-1:0]           hi_addr
);

  logic [PA_W-1:0] base;

  always_comb begin
    case (sel)
      REQ_SEL_W'(SEG_ES): base = bases[SEG_ES];
      REQ_SEL_W'(SEG_CS): base = bases[SEG_CS];
      REQ_SEL_W'(SEG_SS): base = bases[SEG_SS];
      default:            base = bases[SEG_DS];
    endcase
  end

  // Segment-end wrap returns to offset zero of the same segment;
  // otherwise the next byte follows, wrapping at the top of physical space.
  always_comb begin
    lo_addr = base + PA_W'(off);
    if (&off)
      hi_addr = base;
    else
      hi_addr = lo_addr + PA_W'(1);
  end

endmodule

// File: rtl/seg_access_fsm.sv
module seg_access_fsm
  import segmem_pkg::*;
#(
  parameter int PA_W   = 20,
  parameter int BYTE_W = 8,
  localparam int WORD_W = 2 * BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_word,
  input  logic [1:0]        req_op,
  input  logic [WORD_W-1:0] req_wdata,
  input  logic [PA_W-1:0]   lo_addr,
  input  logic [PA_W-1:0]   hi_addr,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [WORD_W-1:0] rsp_rdata,
  input  logic              wb_valid,
  input  logic [WORD_W-1:0] wb_data,
  output logic              mem_en,
  output logic              mem_we,
  output logic [PA_W-1:0]   mem_addr,
  output logic [BYTE_W-1:0] mem_wdata,
  input  logic [BYTE_W-1:0] mem_rdata
);

  acc_state_e        st;
  logic [PA_W-1:0]   a_lo, a_hi;
  logic              is_word;
  op_e               op;
  logic [WORD_W-1:0] wd, rd;
  logic              hi_phase;

  assign hi_phase  = (st == ST_HI) || (st == ST_WB_HI);
  assign req_ready = (st == ST_IDLE);
  assign rsp_valid = (st == ST_RSP);
  assign rsp_rdata = rd;

  always_comb begin
    mem_en    = (st == ST_LO) || (st == ST_HI) || (st == ST_WB_LO) || (st == ST_WB_HI);
    mem_we    = (((st == ST_LO) || (st == ST_HI)) && (op == OP_WR))
              || (st == ST_WB_LO) || (st == ST_WB_HI);
    mem_addr  = hi_phase ? a_hi : a_lo;
    mem_wdata = hi_phase ? wd[WORD_W-1:BYTE_W] : wd[BYTE_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= ST_IDLE;
      a_lo    <= '0;
      a_hi    <= '0;
      is_word <= 1'b0;
      op      <= OP_RD;
      wd      <= '0;
      rd      <= '0;
    end else begin
      case (st)
        ST_IDLE: if (req_valid) begin
          a_lo    <= lo_addr;
          a_hi    <= hi_addr;
          is_word <= req_word;
          op      <= op_e'(req_op);
          wd      <= req_wdata;
          st      <= ST_LO;
        end
        ST_LO:   st <= is_word ? ST_HI : ST_TAIL;
        ST_HI: begin
          rd[BYTE_W-1:0] <= mem_rdata;
          st <= ST_TAIL;
        end
        ST_TAIL: begin
          if (is_word) rd[WORD_W-1:BYTE_W] <= mem_rdata;
          else         rd <= {{BYTE_W{1'b0}}, mem_rdata};
          st <= ST_RSP;
        end
        ST_RSP: if (rsp_ready)
          st <= (op == OP_RMW) ? ST_WAIT_WB : ST_IDLE;
        ST_WAIT_WB: if (wb_valid) begin
          wd <= wb_data;
          st <= ST_WB_LO;
        end
        ST_WB_LO: st <= is_word ? ST_WB_HI : ST_IDLE;
        ST_WB_HI: st <= ST_IDLE;
        default:  st <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/seg_mem_unit.sv
module seg_mem_unit #(
  parameter int OFF_W  = 16,
  parameter int SHIFT  = 4,
  parameter int BYTE_W = 8,
  localparam int PA_W   = OFF_W + SHIFT,
  localparam int WORD_W = 2 * BYTE_W,
  localparam int NSEG   = 4,
  localparam int SEL_W  = $clog2(NSEG),
  localparam int REQ_SEL_W = SEL_W + 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 seg_wr_en,
  input  logic [SEL_W-1:0]     seg_wr_sel,
  input  logic [OFF_W-1:0]     seg_wr_val,
  input  logic                 req_valid,
  output logic                 req_ready,
  input  logic [REQ_SEL_W-1:0] req_sel,
  input  logic [OFF_W-1:0]     req_off,
  input  logic                 req_word,
  input  logic [1:0]           req_op,
  input  logic [WORD_W-1:0]    req_wdata,
  output logic                 rsp_valid,
  input  logic                 rsp_ready,
  output logic [WORD_W-1:0]    rsp_rdata,
  input  logic                 wb_valid,
  input  logic [WORD_W-1:0]    wb_data,
  output logic                 mem_en,
  output logic                 mem_we,
  output logic [PA_W-1:0]      mem_addr,
  output logic [BYTE_W-1:0]    mem_wdata,
  input  logic [BYTE_W-1:0]    mem_rdata
);

  logic [NSEG-1:0][PA_W-1:0] bases;
  logic [PA_W-1:0]           lo_addr, hi_addr;

  seg_base_cache #(
    .SEG_W(OFF_W), .SHIFT(SHIFT), .NSEG(NSEG), .PA_W(PA_W), .RESET_IDX(1)
  ) u_bases (
    .clk(clk), .rst_n(rst_n),
    .wr_en(seg_wr_en), .wr_sel(seg_wr_sel), .wr_val(seg_wr_val),
    .bases(bases)
  );

  seg_addr_gen #(
    .OFF_W(OFF_W), .PA_W(PA_W), .NSEG(NSEG), .REQ_SEL_W(REQ_SEL_W)
  ) u_agen (
    .bases(bases), .sel(req_sel), .off(req_off),
    .lo_addr(lo_addr), .hi_addr(hi_addr)
  );

  seg_access_fsm #(
    .PA_W(PA_W), .BYTE_W(BYTE_W)
  ) u_fsm (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready),
    .req_word(req_word), .req_op(req_op), .req_wdata(req_wdata),
    .lo_addr(lo_addr), .hi_addr(hi_addr),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata),
    .wb_valid(wb_valid), .wb_data(wb_data),
    .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

endmodule

// File: rtl/seg_mem_unit_checker.sv
module seg_mem_unit_checker #(
  parameter int WORD_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              rsp_valid,
  input logic              rsp_ready,
  input logic [WORD_W-1:0] rsp_rdata,
  input logic              mem_en,
  input logic              mem_we
);

  p_rsp_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_rdata)));

  p_single_flight_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  p_no_accept_rsp_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !req_ready);

  p_we_needs_en_r8: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> mem_en);

  p_idle_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !mem_en);

endmodule

bind seg_mem_unit seg_mem_unit_checker #(.WORD_W(WORD_W)) u_checker (
  .clk(clk), .rst_n(rst_n),
  .req_valid(req_valid), .req_ready(req_ready),
  .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata),
  .mem_en(mem_en), .mem_we(mem_we)
);

// File: tb/test_seg_mem_unit.sv
module test_seg_mem_unit;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        seg_wr_en = 1'b0;
  logic [1:0]  seg_wr_sel = '0;
  logic [15:0] seg_wr_val = '0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [2:0]  req_sel = '0;
  logic [15:0] req_off = '0;
  logic        req_word = 1'b0;
  logic [1:0]  req_op = '0;
  logic [15:0] req_wdata = '0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b1;
  logic [15:0] rsp_rdata;
  logic        wb_valid = 1'b0;
  logic [15:0] wb_data = '0;
  logic        mem_en, mem_we;
  logic [19:0] mem_addr;
  logic [7:0]  mem_wdata;
  logic [7:0]  mem_rdata = 8'hFF;

  int tests = 0, fails = 0, cyc = 0;
  int en_cnt = 0;
  logic [19:0] first_addr = '0;
  logic [15:0] segv [4];
  logic [7:0]  ram    [int];
  logic [7:0]  shadow [int];

  always #5 clk = ~clk;

  seg_mem_unit i_seg_mem_unit (
    .clk(clk), .rst_n(rst_n),
    .seg_wr_en(seg_wr_en), .seg_wr_sel(seg_wr_sel), .seg_wr_val(seg_wr_val),
    .req_valid(req_valid), .req_ready(req_ready), .req_sel(req_sel),
    .req_off(req_off), .req_word(req_word), .req_op(req_op), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata),
    .wb_valid(wb_valid), .wb_data(wb_data),
    .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  // Byte RAM model, one-cycle read latency, unloaded bytes read 0xFF.
  always @(posedge clk) begin
    if (mem_en) begin
      if (en_cnt == 0) first_addr <= mem_addr;
      en_cnt <= en_cnt + 1;
      if (mem_we) ram[int'(mem_addr)] = mem_wdata;
      else mem_rdata <= ram.exists(int'(mem_addr)) ? ram[int'(mem_addr)] : 8'hFF;
    end
  end

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      tests++; fails++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int map_sel(input logic [2:0] s);
    return (s < 3) ? int'(s) : 3;
  endfunction

  function automatic logic [19:0] phys(input logic [2:0] s, input logic [15:0] off, input bit hi);
    logic [19:0] base = {segv[map_sel(s)], 4'h0};
    if (!hi) return base + 20'(off);
    if (off == 16'hFFFF) return base;
    return base + 20'(off) + 20'd1;
  endfunction

  function automatic logic [7:0] sh(input logic [19:0] a);
    return shadow.exists(int'(a)) ? shadow[int'(a)] : 8'hFF;
  endfunction

  task automatic seg_set(input int idx, input logic [15:0] v);
    @(negedge clk);
    seg_wr_en = 1'b1; seg_wr_sel = 2'(idx); seg_wr_val = v;
    @(posedge clk); #1;
    seg_wr_en = 1'b0;
    segv[idx] = v;
  endtask

  task automatic do_req(input logic [2:0] s, input logic [15:0] off, input bit word,
                        input logic [1:0] op, input logic [15:0] wdat, input int hold,
                        output logic [15:0] rdat);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    en_cnt = 0;
    req_valid = 1'b1; req_sel = s; req_off = off; req_word = word;
    req_op = op; req_wdata = wdat; rsp_ready = (hold == 0);
    @(posedge clk); #1;
    req_valid = 1'b0;
    @(negedge clk);
    while (!rsp_valid) @(negedge clk);
    rdat = rsp_rdata;
    for (int h = 0; h < hold; h++) begin
      @(negedge clk);
      check(rsp_valid && rsp_rdata == rdat, "R10 held response", {15'd0, rsp_valid, rsp_rdata}, {16'd1, rdat});
    end
    rsp_ready = 1'b1;
    @(posedge clk); #1;
  endtask

  task automatic do_wb(input logic [15:0] v);
    @(negedge clk);
    wb_valid = 1'b1; wb_data = v;
    @(posedge clk); #1;
    wb_valid = 1'b0;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
  endtask

  logic [15:0] r;
  logic [15:0] vals [4] = '{16'h0000, 16'h1234, 16'hF000, 16'hFFFF};
  logic [15:0] offs [6] = '{16'h0000, 16'h0001, 16'h000F, 16'h7FFE, 16'hFFFE, 16'hFFFF};

  initial begin
    segv[0] = 16'h0000; segv[1] = 16'hFFFF; segv[2] = 16'h0000; segv[3] = 16'h0000;
    ram[20'hFFFF0] = 8'hEA; ram[20'hFFFF1] = 8'h5B; ram[0] = 8'h3C;
    shadow[20'hFFFF0] = 8'hEA; shadow[20'hFFFF1] = 8'h5B; shadow[0] = 8'h3C;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    check(req_ready == 1'b1, "R11 reset req_ready", 32'(req_ready), 1);
    check(rsp_valid == 1'b0, "R11 reset rsp_valid", 32'(rsp_valid), 0);
    check(mem_en == 1'b0, "R11 reset idle RAM", 32'(mem_en), 0);

    do_req(3'd1, 16'h0000, 1'b1, 2'd0, 16'h0, 0, r);
    check(r == 16'h5BEA, "R3 first CS fetch", 32'(r), 32'h5BEA);
    check(en_cnt == 2 && first_addr == 20'hFFFF0, "R7 word two cycles low first", 32'(en_cnt), 2);
    for (int s = 0; s < 8; s++) begin
      if (s == 1) continue;
      do_req(3'(s), 16'h0000, 1'b0, 2'd3, 16'h0, 0, r);
      check(r == 16'h003C, "R3 R11 zero bases, op 3 reads", 32'(r), 32'h3C);
      check(en_cnt == 1, "R7 byte one cycle", 32'(en_cnt), 1);
    end

    for (int rr = 0; rr < 4; rr++) begin
      for (int i = 0; i < 4; i++) seg_set(i, vals[(rr + i) % 4]);
      for (int s = 0; s < 8; s++) begin
        for (int k = 0; k < 6; k++) begin
          logic [15:0] wd;
          logic [19:0] lo, hi;
          string tag;
          wd = {8'(rr * 37 + s * 11 + k * 3 + 1), 8'(rr * 53 + s * 7 + k * 5 + 2)};
          lo = phys(3'(s), offs[k], 1'b0);
          hi = phys(3'(s), offs[k], 1'b1);
          tag = (offs[k] == 16'hFFFF) ? "R5 segment wrap" :
                (lo == 20'hFFFFF) ? "R6 physical wrap" : "R1 R2 R4 R8 linear";
          do_req(3'(s), offs[k], 1'b1, 2'd1, wd, 0, r);
          shadow[int'(lo)] = wd[7:0];
          shadow[int'(hi)] = wd[15:8];
          do_req(3'(s), offs[k], 1'b1, 2'd0, 16'h0, 0, r);
          check(r == {sh(hi), sh(lo)}, tag, 32'(r), 32'({sh(hi), sh(lo)}));
          do_req(3'(s), offs[k], 1'b0, 2'd0, 16'h0, 0, r);
          check(r == {8'h00, sh(lo)}, "R1 byte read", 32'(r), 32'(sh(lo)));
        end
      end
    end

    // R9: read-modify-write on a segment-end wrap, then a byte one.
    seg_set(0, 16'h3000);
    do_req(3'd0, 16'hFFFF, 1'b1, 2'd1, 16'hA1B2, 0, r);
    shadow[32'h3FFFF] = 8'hB2; shadow[32'h30000] = 8'hA1;
    do_req(3'd0, 16'hFFFF, 1'b1, 2'd2, 16'h0, 2, r);
    check(r == 16'hA1B2, "R9 rmw old data", 32'(r), 32'hA1B2);
    en_cnt = 0;
    for (int w = 0; w < 4; w++) begin
      @(negedge clk);
      check(req_ready == 1'b0, "R9 held while write-back pending", 32'(req_ready), 0);
    end
    check(en_cnt == 0, "R9 no RAM cycle while pending", 32'(en_cnt), 0);
    do_wb(16'hC3D4);
    shadow[32'h3FFFF] = 8'hD4; shadow[32'h30000] = 8'hC3;
    do_req(3'd0, 16'hFFFF, 1'b1, 2'd0, 16'h0, 0, r);
    check(r == 16'hC3D4, "R9 write-back same addresses", 32'(r), 32'hC3D4);
    do_req(3'd0, 16'h0010, 1'b0, 2'd2, 16'h0, 0, r);
    check(r == {8'h00, sh(20'h30010)}, "R9 byte rmw old", 32'(r), 32'(sh(20'h30010)));
    do_wb(16'hEE77);
    shadow[32'h30010] = 8'h77;
    do_req(3'd0, 16'h0010, 1'b1, 2'd0, 16'h0, 3, r);
    check(r == {sh(20'h30011), 8'h77}, "R9 byte write-back only low", 32'(r), 32'({sh(20'h30011), 8'h77}));

    // R9: stray strobe while idle is ignored.
    en_cnt = 0;
    @(negedge clk); wb_valid = 1'b1; wb_data = 16'h9999;
    @(negedge clk); wb_valid = 1'b0;
    repeat (3) @(negedge clk);
    check(en_cnt == 0 && req_ready, "R9 stray write-back ignored", 32'(en_cnt), 0);

    // Whole-image comparison catches bytes written to wrong places.
    begin
      int bad = 0;
      foreach (ram[k]) if (sh(20'(k)) != ram[k]) bad++;
      foreach (shadow[k]) if (!ram.exists(k) || ram[k] != shadow[k]) bad++;
      check(bad == 0, "R5 R6 R8 RAM image", 32'(bad), 0);
    end
    finish_run();
  end

endmodule